// File: doc/BRIEF.md
# Power-Down and Mute Sequencer

This block sits beside a voice codec's PCM port and decides when the codec is powered down and when its voice path is muted. It watches an active-low power-down pin, the PCM bit clock and the frame sync, all sampled in a free-running reference clock domain. Power-down is entered when the pin goes low or when the bit clock stops in the low state. It is entered only after a fixed entry delay, and a request that disappears before the delay ends is dropped. Power-down is left when the pin is high and both the bit clock and the frame sync are toggling.

Mute stays on for a settling interval after every power-up. While the block is powered down, it drives controls that put the analog outputs in high impedance and force the serial transmit line low. An external active-low mute input forces the zero code into the D/A path without changing the power state. Every delay, and both clock-idle windows, are parameters counted in reference-clock cycles.

Top module: `pwr_mute_seq`

## Requirements
- R1: While rst_ni is low, pwrdn_o, mute_o, ana_hiz_o, dx_force_low_o and dac_zero_o are all 1.
- R2: When pdn_ni goes low in the normal running state, pwrdn_o rises ENTRY_CYC+3 reference cycles later. This count includes two synchroniser stages and one cycle to register the state.
- R3: When bclk_i stops low after its last falling edge, pwrdn_o rises BCLK_IDLE_CYC+ENTRY_CYC+4 reference cycles after that edge, provided pdn_ni stays high.
- R4: A bit clock stopped high never causes power-down, however long it stays high.
- R5: pwrdn_o falls only when pdn_ni is high and both bclk_i and fs_i show an edge within their idle windows (BCLK_IDLE_CYC and FS_IDLE_CYC). With fs_i stopped, the block stays powered down.
- R6: After pwrdn_o falls, mute_o stays 1 for exactly MUTE_CYC reference cycles and then falls. It never falls in the same cycle that power-down ends.
- R7: A power-down request that clears before ENTRY_CYC cycles have passed returns the block to its previous state. From the running state, pwrdn_o and mute_o stay 0. From the muted state, mute_o stays 1 and pwrdn_o stays 0.
- R8: While pwrdn_o is 1, ana_hiz_o, dx_force_low_o, mute_o and dac_zero_o are all 1.
- R9: dac_zero_o is 1 whenever mute_o is 1, and also within three cycles of mute_ni being low. mute_ni has no effect on pwrdn_o or mute_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pdn_ni | input | 1 | Power-down pin, low requests power-down |
| bclk_i | input | 1 | PCM bit clock (asynchronous) |
| fs_i | input | 1 | Frame sync (asynchronous) |
| mute_ni | input | 1 | External mute, low forces zero code to D/A |
| pwrdn_o | output | 1 | Internal power-down |
| mute_o | output | 1 | Voice-path mute from the sequencer |
| dac_zero_o | output | 1 | Feed zero code to the D/A path |
| ana_hiz_o | output | 1 | High-impedance enable for the analog outputs |
| dx_force_low_o | output | 1 | Force the serial transmit line low |

## Verification
The assertions assume that pdn_ni, bclk_i, fs_i and mute_ni are asynchronous to clk_i. They also assume that any edge of these inputs lasts at least two reference cycles, so that the synchronisers catch it. The stimulus changes every input on the falling reference edge. It runs the bit clock at four reference cycles per phase and the frame sync with a 64-cycle period. Both are well inside the shortened idle windows, so a running clock is never taken for a stopped one. Stops are timed from a known bit clock level, which keeps the expected power-down cycle exact.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    ST_PWRDN = 2'd0,
    ST_WAIT  = 2'd1,
    ST_MUTED = 2'd2,
    ST_RUN   = 2'd3
  } pms_state_e;
endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pms_activity.sv
module pms_activity #(
  parameter int unsigned IDLE_CYC = 16,
  localparam int unsigned CW = $clog2(IDLE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic active_o,
  output logic stopped_low_o
);
  logic          prev_q;
  logic [CW-1:0] idle_q;
  logic          edge_seen;

  assign edge_seen = lvl_i ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      idle_q <= CW'(IDLE_CYC);   // idle until an edge is seen
    end else begin
      prev_q <= lvl_i;
      if (edge_seen)                     idle_q <= '0;
      else if (idle_q != CW'(IDLE_CYC))  idle_q <= idle_q + 1'b1;
    end
  end

  assign active_o      = (idle_q != CW'(IDLE_CYC));
  assign stopped_low_o = !active_o && !prev_q;
endmodule

// File: rtl/pms_timer.sv
module pms_timer #(
  parameter int unsigned LIMIT = 40,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 cnt_q <= '0;
    else if (clr_i)                              cnt_q <= '0;
    else if (en_i && cnt_q != CW'(LIMIT - 1))    cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = en_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       release_ok_i,
  input  logic       entry_exp_i,
  input  logic       mute_exp_i,
  output pms_state_e state_o,
  output logic       mute_o
);
  pms_state_e state_q, state_d, ret_q, ret_d;

  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    unique case (state_q)
      ST_PWRDN: if (release_ok_i && !req_i) state_d = ST_MUTED;
      ST_MUTED: begin
        if (req_i) begin
          state_d = ST_WAIT;
          ret_d   = ST_MUTED;
        end else if (mute_exp_i) begin
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (req_i) begin
          state_d = ST_WAIT;
          ret_d   = ST_RUN;
        end
      end
      ST_WAIT: begin
        if (!req_i)          state_d = ret_q;
        else if (entry_exp_i) state_d = ST_PWRDN;
      end
      default: state_d = ST_PWRDN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWRDN;
      ret_q   <= ST_MUTED;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
    end
  end

  assign state_o = state_q;
  assign mute_o  = (state_q == ST_PWRDN) || (state_q == ST_MUTED) ||
                   ((state_q == ST_WAIT) && (ret_q == ST_MUTED));
endmodule

// File: rtl/pwr_mute_seq.sv
module pwr_mute_seq
  import pms_pkg::*;
#(
  parameter int unsigned ENTRY_CYC     = 600,
  parameter int unsigned MUTE_CYC      = 200000,
  parameter int unsigned BCLK_IDLE_CYC = 320,
  parameter int unsigned FS_IDLE_CYC   = 2600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pdn_ni,
  input  logic bclk_i,
  input  logic fs_i,
  input  logic mute_ni,
  output logic pwrdn_o,
  output logic mute_o,
  output logic dac_zero_o,
  output logic ana_hiz_o,
  output logic dx_force_low_o
);
  localparam int unsigned NSYNC = 4;

  logic [NSYNC-1:0] raw_in, syn;
  logic pdn_n_s, bclk_s, fs_s, mute_n_s;
  logic bclk_act, bclk_low_stop, fs_act, fs_low_stop_unused;
  logic pd_req, release_ok;
  logic entry_exp, mute_exp;
  logic seq_mute;
  pms_state_e state;

  assign raw_in = {mute_ni, fs_i, bclk_i, pdn_ni};

  pms_sync #(.W(NSYNC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_in), .q_o(syn)
  );

  assign {mute_n_s, fs_s, bclk_s, pdn_n_s} = syn;

  pms_activity #(.IDLE_CYC(BCLK_IDLE_CYC)) u_bclk_act (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(bclk_s),
    .active_o(bclk_act), .stopped_low_o(bclk_low_stop)
  );

  pms_activity #(.IDLE_CYC(FS_IDLE_CYC)) u_fs_act (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(fs_s),
    .active_o(fs_act), .stopped_low_o(fs_low_stop_unused)
  );

  // a bit clock parked high is not a request
  assign pd_req     = !pdn_n_s || bclk_low_stop;
  assign release_ok = pdn_n_s && bclk_act && fs_act;

  pms_timer #(.LIMIT(ENTRY_CYC)) u_entry_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(state != ST_WAIT), .en_i(state == ST_WAIT),
    .expire_o(entry_exp)
  );

  // held, not cleared, across an aborted entry from the muted state
  pms_timer #(.LIMIT(MUTE_CYC)) u_mute_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(state == ST_PWRDN), .en_i(state == ST_MUTED),
    .expire_o(mute_exp)
  );

  pms_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(pd_req), .release_ok_i(release_ok),
    .entry_exp_i(entry_exp), .mute_exp_i(mute_exp),
    .state_o(state), .mute_o(seq_mute)
  );

  assign pwrdn_o        = (state == ST_PWRDN);
  assign mute_o         = seq_mute;
  assign dac_zero_o     = seq_mute || !mute_n_s;
  assign ana_hiz_o      = pwrdn_o;
  assign dx_force_low_o = pwrdn_o;
endmodule

// File: rtl/pms_checker.sv
module pms_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic mute_ni,
  input logic pwrdn_o,
  input logic mute_o,
  input logic dac_zero_o,
  input logic ana_hiz_o,
  input logic dx_force_low_o,
  input logic req_i,
  input logic rel_i
);
  p_entry_needs_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwrdn_o) |-> $past(req_i));

  p_release_cond_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwrdn_o) |-> $past(rel_i));

  p_powerup_muted_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwrdn_o) |-> mute_o);

  p_unmute_after_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mute_o) |-> (!pwrdn_o && $past(!pwrdn_o)));

  p_pd_outputs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrdn_o |-> (ana_hiz_o && dx_force_low_o && mute_o && dac_zero_o));

  p_mute_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o |-> dac_zero_o);

  p_ext_mute_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mute_ni && $past(!mute_ni) && $past(!mute_ni, 2)) |-> dac_zero_o);
endmodule

bind pwr_mute_seq pms_checker u_pms_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .mute_ni(mute_ni),
  .pwrdn_o(pwrdn_o), .mute_o(mute_o), .dac_zero_o(dac_zero_o),
  .ana_hiz_o(ana_hiz_o), .dx_force_low_o(dx_force_low_o),
  .req_i(pd_req), .rel_i(release_ok)
);

// File: tb/pwr_mute_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_mute_seq_tb_top;
  localparam int ENTRY = 40;
  localparam int MUTE  = 200;
  localparam int BIDLE = 16;
  localparam int FIDLE = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pdn_n = 1'b1, mute_n = 1'b1;
  logic bclk = 1'b0, fs = 1'b0;
  logic bclk_run = 1'b0, bclk_hold = 1'b0, fs_run = 1'b0;
  logic [1:0] bdiv = '0;
  logic [5:0] fdiv = '0;
  logic pwrdn, mute, dac_zero, ana_hiz, dx_low;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_mute_seq #(
    .ENTRY_CYC(ENTRY), .MUTE_CYC(MUTE),
    .BCLK_IDLE_CYC(BIDLE), .FS_IDLE_CYC(FIDLE)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pdn_ni(pdn_n), .bclk_i(bclk), .fs_i(fs),
    .mute_ni(mute_n), .pwrdn_o(pwrdn), .mute_o(mute), .dac_zero_o(dac_zero),
    .ana_hiz_o(ana_hiz), .dx_force_low_o(dx_low)
  );

  always @(negedge clk) begin
    if (bclk_run) begin
      bdiv <= bdiv + 2'd1;
      if (bdiv == 2'd3) bclk <= ~bclk;
    end else bclk <= bclk_hold;
    if (fs_run) begin
      fdiv <= fdiv + 6'd1;
      fs   <= (fdiv < 6'd8);
    end else fs <= 1'b0;
  end

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic chk_rng(input string rq, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", rq, act, lo, hi);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pd(input logic want, input int lim, output int n);
    n = 0;
    while (pwrdn !== want && n < lim) begin tick(1); n++; end
    if (pwrdn !== want) n = -1;
  endtask

  task automatic wait_mute(input logic want, input int lim, output int n);
    n = 0;
    while (mute !== want && n < lim) begin tick(1); n++; end
    if (mute !== want) n = -1;
  endtask

  task automatic recover();
    int n;
    wait_pd(1'b0, 1000, n);
    chk_rng("R5 recover pd", n, 0, 1000);
    wait_mute(1'b0, 1000, n);
    chk_rng("R6 recover mute", n, 0, 1000);
  endtask

  task automatic t_reset();
    tick(3);
    chk("R1 pwrdn", pwrdn, 1);
    chk("R1 mute", mute, 1);
    chk("R1 hiz", ana_hiz, 1);
    chk("R1 dxlow", dx_low, 1);
    chk("R1 dac_zero", dac_zero, 1);
  endtask

  task automatic t_powerup();
    int n;
    bclk_run = 1'b1;
    tick(2);
    rst_n = 1'b1;
    tick(200);
    chk("R5 no fs stays down", pwrdn, 1);
    fs_run = 1'b1;
    wait_pd(1'b0, 400, n);
    chk_rng("R5 release with clocks", n, 1, 400);
    chk("R6 muted at powerup", mute, 1);
    chk("R9 dac zero while muted", dac_zero, 1);
    wait_mute(1'b0, 2 * MUTE, n);
    chk("R6 mute hold length", n, MUTE);
  endtask

  task automatic t_pin_pd();
    int n;
    pdn_n = 1'b0;
    wait_pd(1'b1, 4 * ENTRY, n);
    chk("R2 entry delay", n, ENTRY + 3);
    chk("R8 hiz", ana_hiz, 1);
    chk("R8 dxlow", dx_low, 1);
    chk("R8 mute", mute, 1);
    chk("R8 dac_zero", dac_zero, 1);
    pdn_n = 1'b1;
    recover();
  endtask

  task automatic t_abort_run();
    int hit_pd = 0, hit_mute = 0;
    pdn_n = 1'b0;
    for (int i = 0; i < ENTRY + 40; i++) begin
      if (i == ENTRY / 2) pdn_n = 1'b1;
      tick(1);
      if (pwrdn) hit_pd++;
      if (mute) hit_mute++;
    end
    chk("R7 abort from run pd", hit_pd, 0);
    chk("R7 abort from run mute", hit_mute, 0);
  endtask

  task automatic t_abort_muted();
    int n, hit_pd = 0, unmuted = 0;
    pdn_n = 1'b0;
    wait_pd(1'b1, 4 * ENTRY, n);
    pdn_n = 1'b1;
    wait_pd(1'b0, 1000, n);
    tick(20);
    pdn_n = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (i == 10) pdn_n = 1'b1;
      tick(1);
      if (pwrdn) hit_pd++;
      if (!mute) unmuted++;
    end
    chk("R7 abort from muted pd", hit_pd, 0);
    chk("R7 abort from muted mute", unmuted, 0);
    recover();
  endtask

  task automatic t_bclk_low();
    int n;
    while (bclk !== 1'b1) tick(1);
    bclk_hold = 1'b0;
    bclk_run  = 1'b0;
    wait_pd(1'b1, 4 * (ENTRY + BIDLE), n);
    chk("R3 bclk stop low", n, BIDLE + ENTRY + 4);
    bclk_run = 1'b1;
    recover();
  endtask

  task automatic t_bclk_high();
    int hit = 0;
    while (bclk !== 1'b0) tick(1);
    bclk_hold = 1'b1;
    bclk_run  = 1'b0;
    for (int i = 0; i < 6 * (ENTRY + BIDLE); i++) begin
      tick(1);
      if (pwrdn) hit++;
    end
    chk("R4 bclk stop high ignored", hit, 0);
    chk("R4 mute unchanged", mute, 0);
    bclk_run = 1'b1;
    tick(20);
  endtask

  task automatic t_ext_mute();
    chk("R9 dac idle", dac_zero, 0);
    mute_n = 1'b0;
    tick(3);
    chk("R9 ext mute zero", dac_zero, 1);
    chk("R9 ext mute no seq mute", mute, 0);
    chk("R9 ext mute no pd", pwrdn, 0);
    mute_n = 1'b1;
    tick(3);
    chk("R9 ext mute released", dac_zero, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_pin_pd();
    t_abort_run();
    t_abort_muted();
    t_bclk_low();
    t_bclk_high();
    t_ext_mute();
    finish_run();
  end

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule